// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a small processor core in 31 storage entries. The core's call and return logic, and its software push and pop instructions, share one pair of strobes: `push_i` stores the program counter given on `pc_in`, and `pop_i` hands back the top entry on `ret_pc`. The strobes are accepted in every cycle and nothing stalls them, so the block has no ready output and applies no back-pressure. `ret_pc` always shows the current top entry, or zero when the stack is empty, and the core takes it in the same cycle it pops.

A byte-wide register port lets software inspect the stack. One address holds the pointer and two sticky status flags: one for a stack that became full and one for a pop from an empty stack. The three other addresses show the top entry as low, high and upper bytes, and software can write those bytes. The static `ovf_rst_en` input selects what happens when the stack fills. With it set, the block stores a corrected address, raises a one-cycle reset request and rewinds the pointer. With it clear, the pointer saturates and later pushes overwrite nothing.

Top module: `rstk_top`

## Requirements
- R1: After power-on reset the pointer is 0, both flags are 0, `ovf_rst_req` is 0, the status register (address 0) reads 0x00 and `ret_pc` reads 0.
- R2: A push first increments the pointer and then stores `pc_in` at the new pointer. A pop reads the current top entry on `ret_pc` in the same cycle and then decrements the pointer, so values come back in last-in first-out order.
- R3: With `ovf_rst_en` = 1, a push that takes the pointer from 30 to 31 stores `pc_in` + 2 (modulo 2^21) in entry 31 and sets the full flag (status bit 7). The pointer becomes 0, and `ovf_rst_req` is high for exactly the one cycle after that push. The full flag stays set.
- R4: With `ovf_rst_en` = 0, a push that takes the pointer to 31 stores `pc_in` and sets the full flag. Any further push leaves entry 31 unchanged and keeps the pointer at 31.
- R5: A pop while the pointer is 0 gives `ret_pc` = 0 in that cycle, sets the underflow flag (status bit 6) and keeps the pointer at 0.
- R6: Status register layout: bit 7 full, bit 6 underflow, bit 5 reads 0, bits 4:0 the pointer. A write loads the pointer from bits 4:0. Writing 0 to bit 7 or bit 6 clears that flag, writing 1 leaves it unchanged, and only a write of 0 or a reset clears a flag.
- R7: Address 1 reads and writes bits 7:0 of the top entry, address 2 bits 15:8 and address 3 bits 20:16, with bits 7:5 of address 3 reading 0. While the pointer is 0, all three addresses read 0 and writes to them have no effect.
- R8: When push and pop are both high, only the push takes effect. A register write in a cycle with a push or a pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears everything |
| ovf_rst_en | input | 1 | Static policy: 1 requests a reset on overflow, 0 saturates |
| push_i | input | 1 | Push strobe (call or software push) |
| pop_i | input | 1 | Pop strobe (return or software pop) |
| pc_in | input | 21 | Program counter value to push |
| ret_pc | output | 21 | Current top entry, 0 when empty |
| ovf_rst_req | output | 1 | One-cycle stack-overflow reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 low, 2 high, 3 upper |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
A pointer that drifts off by one shows up on the very next pop as the wrong `ret_pc` value, and as the wrong low five bits of the status register as soon as that register is read. A wrong entry stays hidden until the pointer comes back to it, so the directed scenarios pop each stack down completely and read entries back through the byte windows. A lost or duplicated flag update shows in the status register the cycle after the push or pop that caused it. An overflow-policy error shows within one cycle as a missing or extra `ovf_rst_req` pulse or a pointer that did not rewind.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  // Status register pointer field is fixed at five bits by the register layout.
  localparam int SP_W  = 5;
  localparam int PAD_W = 24;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_TOSL = 2'd1,
    SEL_TOSH = 2'd2,
    SEL_TOSU = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            keep_full;
    logic            keep_unf;
    logic [SP_W-1:0] ptr;
  } stat_wr_t;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int PC_W  = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_rst_en,
  input  logic             push,
  input  logic             pop,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             stat_we,
  input  stat_wr_t         stat_wr,
  output logic [SP_W-1:0]  ptr,
  output logic             full,
  output logic             unf,
  output logic             ovf_rst_req,
  output logic             push_we,
  output logic [SP_W-1:0]  push_idx,
  output logic [PC_W-1:0]  push_data
);
  localparam logic [SP_W-1:0] TOP_IDX  = SP_W'(DEPTH);
  localparam logic [SP_W-1:0] LAST_IDX = SP_W'(DEPTH - 1);

  logic            do_pop;
  logic            do_stat;
  logic            at_top;
  logic            reach;
  logic [SP_W-1:0] ptr_inc;
  logic [SP_W-1:0] ptr_dec;
  logic [SP_W-1:0] ptr_wr;

  assign do_pop  = pop & ~push;
  assign do_stat = stat_we & ~push & ~pop;
  assign at_top  = (ptr == TOP_IDX);
  assign reach   = push && (ptr == LAST_IDX);
  assign ptr_inc = ptr + 1'b1;
  assign ptr_dec = ptr - 1'b1;
  assign ptr_wr  = (stat_wr.ptr > TOP_IDX) ? TOP_IDX : stat_wr.ptr;

  assign push_we   = push && !at_top;
  assign push_idx  = ptr_inc;
  assign push_data = (reach && ovf_rst_en) ? pc_in + PC_W'(2) : pc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr         <= '0;
      full        <= 1'b0;
      unf         <= 1'b0;
      ovf_rst_req <= 1'b0;
    end else begin
      ovf_rst_req <= 1'b0;
      if (push) begin
        if (at_top || reach) begin
          full <= 1'b1;
          if (ovf_rst_en) begin
            ptr         <= '0;
            ovf_rst_req <= 1'b1;
          end else begin
            ptr <= TOP_IDX;
          end
        end else begin
          ptr <= ptr_inc;
        end
      end else if (do_pop) begin
        if (ptr == '0) unf <= 1'b1;
        else           ptr <= ptr_dec;
      end else if (do_stat) begin
        ptr  <= ptr_wr;
        full <= full & stat_wr.keep_full;
        unf  <= unf & stat_wr.keep_unf;
      end
    end
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ptr < LAST_IDX) |=> (ptr == $past(ptr) + 1'b1)); // R2
  AST_OVF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ptr == LAST_IDX && ovf_rst_en) |=> (ovf_rst_req && full && ptr == '0)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_rst_req |=> !ovf_rst_req); // R3
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && at_top && !ovf_rst_en) |=> (ptr == TOP_IDX && full)); // R4
  AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ptr == '0) |=> (unf && ptr == '0)); // R5
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(stat_we && !push && !pop && !stat_wr.keep_full)) |=> full); // R6
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !(stat_we && !push && !pop && !stat_wr.keep_unf)) |=> unf); // R6
  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && ptr != '0 && ptr < LAST_IDX) |=> (ptr != $past(ptr) - 1'b1)); // R8
endmodule

// File: rtl/rstk_store.sv
module rstk_store
  import rstk_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int PC_W  = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_we,
  input  logic [SP_W-1:0] push_idx,
  input  logic [PC_W-1:0] push_data,
  input  logic            tos_we,
  input  logic [PC_W-1:0] tos_wdata,
  input  logic [SP_W-1:0] rd_idx,
  output logic [PC_W-1:0] rd_data
);
  localparam int SLOTS = 1 << SP_W;

  logic [PC_W-1:0] rows [0:SLOTS-1];

  assign rows[0] = '0;

  for (genvar e = 1; e < SLOTS; e++) begin : g_slot
    if (e <= DEPTH) begin : g_ent
      logic [PC_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  q <= '0;
        else if (push_we && push_idx == SP_W'(e))    q <= push_data;
        else if (tos_we && rd_idx == SP_W'(e))       q <= tos_wdata;
      end
      assign rows[e] = q;
    end else begin : g_none
      assign rows[e] = '0;
    end
  end

  assign rd_data = rows[rd_idx];
endmodule

// File: rtl/rstk_regif.sv
module rstk_regif
  import rstk_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic            busy,
  input  logic [SP_W-1:0] ptr,
  input  logic            full,
  input  logic            unf,
  input  logic [PC_W-1:0] tos,
  output logic [7:0]      reg_rdata,
  output logic            stat_we,
  output stat_wr_t        stat_wr,
  output logic            tos_we,
  output logic [PC_W-1:0] tos_wdata
);
  reg_sel_e         sel;
  logic [PAD_W-1:0] tos_pad;

  assign sel     = reg_sel_e'(reg_addr);
  assign tos_pad = PAD_W'(tos);

  assign stat_we = reg_wr && (sel == SEL_STAT) && !busy;
  assign stat_wr = '{keep_full: reg_wdata[7], keep_unf: reg_wdata[6],
                     ptr: reg_wdata[SP_W-1:0]};
  assign tos_we  = reg_wr && (sel != SEL_STAT) && !busy && (ptr != '0);

  for (genvar b = 0; b < PC_W; b++) begin : g_bit
    localparam int LANE = b / 8;
    assign tos_wdata[b] = (reg_addr == 2'(LANE + 1)) ? reg_wdata[b % 8] : tos[b];
  end

  always_comb begin
    case (sel)
      SEL_STAT: reg_rdata = {full, unf, 1'b0, ptr};
      SEL_TOSL: reg_rdata = tos_pad[7:0];
      SEL_TOSH: reg_rdata = tos_pad[15:8];
      SEL_TOSU: reg_rdata = tos_pad[23:16];
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rstk_top.sv
module rstk_top
  import rstk_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int PC_W  = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovf_rst_en,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] ret_pc,
  output logic            ovf_rst_req,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata
);
  localparam logic [SP_W-1:0] LAST_IDX = SP_W'(DEPTH - 1);

  logic [SP_W-1:0] ptr;
  logic            full;
  logic            unf;
  logic            push_we;
  logic [SP_W-1:0] push_idx;
  logic [PC_W-1:0] push_data;
  logic            stat_we;
  stat_wr_t        stat_wr;
  logic            tos_we;
  logic [PC_W-1:0] tos_wdata;
  logic [PC_W-1:0] tos;

  rstk_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ovf_rst_en(ovf_rst_en),
    .push(push_i), .pop(pop_i), .pc_in(pc_in),
    .stat_we(stat_we), .stat_wr(stat_wr),
    .ptr(ptr), .full(full), .unf(unf), .ovf_rst_req(ovf_rst_req),
    .push_we(push_we), .push_idx(push_idx), .push_data(push_data)
  );

  rstk_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_we(push_we), .push_idx(push_idx), .push_data(push_data),
    .tos_we(tos_we), .tos_wdata(tos_wdata),
    .rd_idx(ptr), .rd_data(tos)
  );

  rstk_regif #(.PC_W(PC_W)) u_regif (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(push_i | pop_i), .ptr(ptr), .full(full), .unf(unf), .tos(tos),
    .reg_rdata(reg_rdata), .stat_we(stat_we), .stat_wr(stat_wr),
    .tos_we(tos_we), .tos_wdata(tos_wdata)
  );

  assign ret_pc = tos;

  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr < LAST_IDX) |=> (ret_pc == $past(pc_in))); // R2
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == '0 && reg_addr != 2'd0) |-> (reg_rdata == 8'h00 && ret_pc == '0)); // R7
endmodule

// File: tb/sim_rstk_top.sv
module sim_rstk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovf_rst_en = 1'b0;
  logic        push_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [20:0] pc_in = '0;
  logic [20:0] ret_pc;
  logic        ovf_rst_req;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstk_top u0 (
    .clk(clk), .rst_n(rst_n), .ovf_rst_en(ovf_rst_en),
    .push_i(push_i), .pop_i(pop_i), .pc_in(pc_in), .ret_pc(ret_pc),
    .ovf_rst_req(ovf_rst_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic push(input logic [20:0] pc);
    @(negedge clk); push_i = 1'b1; pc_in = pc;
    @(negedge clk); push_i = 1'b0;
  endtask

  task automatic pop(output logic [20:0] r);
    @(negedge clk); pop_i = 1'b1; #1 r = ret_pc;
    @(negedge clk); pop_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d);
    chk("R1", "status after reset", d, 8'h00);
    chk("R1", "reset request idle", ovf_rst_req, 1'b0);
    chk("R1", "ret_pc after reset", ret_pc, 21'h0);
  endtask

  task automatic t_push_pop();
    logic [20:0] r;
    logic [7:0] d;
    push(21'h1ABCD); push(21'h00042); push(21'h1FFFFF);
    rd(2'd0, d);
    chk("R2", "pointer after three pushes", d, 8'h03);
    pop(r); chk("R2", "first pop", r, 21'h1FFFFF);
    pop(r); chk("R2", "second pop", r, 21'h00042);
    pop(r); chk("R2", "third pop", r, 21'h1ABCD);
    rd(2'd0, d);
    chk("R2", "status after unload", d, 8'h00);
  endtask

  task automatic t_underflow();
    logic [20:0] r;
    logic [7:0] d;
    pop(r);
    chk("R5", "empty pop value", r, 21'h0);
    rd(2'd0, d);
    chk("R5", "underflow flag and pointer", d, 8'h40);
    wr(2'd0, 8'h40);
    rd(2'd0, d);
    chk("R6", "writing 1 keeps underflow flag", d, 8'h40);
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    chk("R6", "writing 0 clears underflow flag", d, 8'h00);
  endtask

  task automatic t_saturate();
    logic [20:0] r;
    logic [7:0] d;
    ovf_rst_en = 1'b0;
    for (int i = 1; i <= 30; i++) push(21'(i));
    rd(2'd0, d);
    chk("R4", "thirty pushes not full", d, 8'h1E);
    push(21'd31);
    rd(2'd0, d);
    chk("R4", "full at 31", d, 8'h9F);
    chk("R4", "no reset request", ovf_rst_req, 1'b0);
    push(21'h777);
    rd(2'd0, d);
    chk("R4", "pointer held at 31", d, 8'h9F);
    rd(2'd1, d);
    chk("R4", "entry 31 not overwritten", d, 8'h1F);
    pop(r);
    chk("R4", "pop from 31", r, 21'd31);
    rd(2'd0, d);
    chk("R6", "full flag sticky after pop", d, 8'h9E);
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    chk("R6", "pointer write and full clear", d, 8'h00);
  endtask

  task automatic t_overflow_reset();
    logic [7:0] d;
    ovf_rst_en = 1'b1;
    for (int i = 1; i <= 30; i++) push(21'h100 + 21'(i));
    rd(2'd0, d);
    chk("R3", "thirty pushes", d, 8'h1E);
    push(21'h1FFFFF);
    chk("R3", "reset request raised", ovf_rst_req, 1'b1);
    rd(2'd0, d);
    chk("R3", "pointer rewound, full kept", d, 8'h80);
    @(negedge clk);
    chk("R3", "reset request one cycle", ovf_rst_req, 1'b0);
    wr(2'd0, 8'h9F);
    rd(2'd1, d); chk("R3", "entry 31 low byte is pc+2", d, 8'h01);
    rd(2'd2, d); chk("R3", "entry 31 high byte", d, 8'h00);
    rd(2'd3, d); chk("R3", "entry 31 upper byte", d, 8'h00);
    wr(2'd0, 8'h00);
    ovf_rst_en = 1'b0;
  endtask

  task automatic t_tos_regs();
    logic [20:0] r;
    logic [7:0] d;
    rd(2'd1, d); chk("R7", "low byte when empty", d, 8'h00);
    rd(2'd3, d); chk("R7", "upper byte when empty", d, 8'h00);
    push(21'h12345);
    rd(2'd3, d); chk("R7", "upper byte", d, 8'h01);
    rd(2'd2, d); chk("R7", "high byte", d, 8'h23);
    rd(2'd1, d); chk("R7", "low byte", d, 8'h45);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R7", "upper byte keeps bits 7:5 zero", d, 8'h1F);
    wr(2'd2, 8'hAB);
    rd(2'd2, d); chk("R7", "high byte written", d, 8'hAB);
    pop(r); chk("R7", "pop of edited entry", r, 21'h1FAB45);
    wr(2'd1, 8'h55);
    wr(2'd0, 8'h01);
    rd(2'd1, d); chk("R7", "write while empty ignored", d, 8'h45);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    @(negedge clk); push_i = 1'b1; pop_i = 1'b1; pc_in = 21'h0AAAA;
    @(negedge clk); push_i = 1'b0; pop_i = 1'b0;
    rd(2'd0, d); chk("R8", "push wins over pop", d, 8'h02);
    rd(2'd1, d); chk("R8", "pushed low byte", d, 8'hAA);
    @(negedge clk); push_i = 1'b1; pc_in = 21'h00111;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h1F;
    @(negedge clk); push_i = 1'b0; reg_wr = 1'b0;
    rd(2'd0, d); chk("R8", "register write ignored during push", d, 8'h03);
    @(negedge clk); pop_i = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h1F;
    @(negedge clk); pop_i = 1'b0; reg_wr = 1'b0;
    rd(2'd0, d); chk("R8", "register write ignored during pop", d, 8'h02);
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_underflow();
    t_saturate();
    t_overflow_reset();
    t_tos_regs();
    t_priority();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule